// File: doc/BRIEF.md
# Debounced Three-Key Setting Controller

This block sits between three raw push-buttons and the calendar and clock counters of a time-of-day unit. Each button is brought into the clock domain through a two-flop synchronizer, then filtered by a stability counter. A press is accepted only after the synchronized level has held for a programmable number of cycles, which defaults to about 10 ms at 125 MHz. Every accepted press yields exactly one single-cycle event.

The mode key steps the unit through a fixed loop: run, date setting, time setting, then run again. In either setting mode, the select key walks across six digit positions and wraps back to the first. The increment key then sends a one-cycle strobe to the counter digit that is selected. In date setting the digit order is year tens, year units, month tens, month units, day tens, day units. In time setting it is hour tens, hour units, minute tens, minute units, second tens, second units.

Together with each selection, the block reports the top legal value of the selected digit. A counter digit that receives a strobe while it holds that value returns to zero. An LED output is lit while a setting mode is active.

Top module: `keySetCtrl`

## Requirements
- R1: After reset, modeOut is 0 (run), digitSel is 0, ledSetting is 0, digitMax is 0 and no strobe bit is set.
- R2: Each accepted press of keyRaw[0] moves modeOut from 0 (run) to 1 (date setting), from 1 to 2 (time setting), and from 2 back to 0. No other mode value ever appears.
- R3: A key level that holds for fewer than DEB_CYCLES synchronized cycles has no effect. A press held for any length of time beyond that produces exactly one action.
- R4: In a setting mode, each accepted press of keyRaw[1] advances digitSel by one. From 5 it wraps to 0, and digitSel never exceeds 5.
- R5: Every mode change sets digitSel to 0.
- R6: In run mode, presses of keyRaw[1] and keyRaw[2] are ignored. digitSel stays 0 and no strobe bit is set.
- R7: In date setting, an accepted press of keyRaw[2] sets dateIncStb bit digitSel for exactly one cycle. No other bit of dateIncStb or timeIncStb is set.
- R8: In time setting, an accepted press of keyRaw[2] sets timeIncStb bit digitSel for exactly one cycle. No other bit of dateIncStb or timeIncStb is set.
- R9: digitMax gives the top value of the selected digit. For digits 0 to 5 it is 9,9,1,9,3,9 in date setting and 2,9,5,9,5,9 in time setting. It is 0 in run mode.
- R10: ledSetting is 1 exactly when modeOut is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyRaw | input | 3 | Raw button levels, 1 = pressed; bit 0 mode, bit 1 select, bit 2 increment |
| modeOut | output | 2 | 0 run, 1 date setting, 2 time setting |
| digitSel | output | 3 | Selected digit position, 0 to 5 |
| dateIncStb | output | 6 | One-cycle increment strobe per date digit |
| timeIncStb | output | 6 | One-cycle increment strobe per time digit |
| digitMax | output | 4 | Top legal value of the selected digit |
| ledSetting | output | 1 | Lit while a setting mode is active |

## Verification
The hardest case to reach is a single long press, because it must produce one event and no more. An accepted level that stays high must not re-arm the filter. The stimulus holds the increment key for several filter windows, and the scoreboard flags any strobe beyond the one it was told to expect. Sub-threshold glitches are driven on the mode and increment keys, and the bench then confirms that the mode and strobe outputs are unchanged. A mode change made after the selection has been stepped away from zero shows the selection returning to the first digit.

// File: rtl/keySetPkg.sv
package keySetPkg;

  localparam int NUM_KEYS   = 3;
  localparam int NUM_DIGITS = 6;
  localparam int SEL_W      = $clog2(NUM_DIGITS);

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_DATE = 2'd1,
    MODE_TIME = 2'd2
  } setMode_e;

  typedef struct packed {
    logic             incReq;
    setMode_e         mode;
    logic [SEL_W-1:0] digit;
  } ctrlToPath_t;

  function automatic logic [3:0] digitTop(input setMode_e m, input logic [SEL_W-1:0] d);
    logic [3:0] top;
    top = 4'd0;
    if (m == MODE_DATE) begin
      case (d)
        3'd2:    top = 4'd1;
        3'd4:    top = 4'd3;
        default: top = 4'd9;
      endcase
    end else if (m == MODE_TIME) begin
      case (d)
        3'd0:       top = 4'd2;
        3'd2, 3'd4: top = 4'd5;
        default:    top = 4'd9;
      endcase
    end
    return top;
  endfunction

endpackage

// File: rtl/keyDebounce.sv
module keyDebounce #(
  parameter int DEB_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyIn,
  output logic pressPulse
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic             syncA;
  logic             syncB;
  logic             stableLvl;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA      <= 1'b0;
      syncB      <= 1'b0;
      stableLvl  <= 1'b0;
      holdCnt    <= '0;
      pressPulse <= 1'b0;
    end else begin
      syncA      <= keyIn;
      syncB      <= syncA;
      pressPulse <= 1'b0;
      if (syncB == stableLvl) begin
        holdCnt <= '0;
      end else if (holdCnt == CNT_LAST) begin
        holdCnt    <= '0;
        stableLvl  <= syncB;
        pressPulse <= syncB;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/setControl.sv
module setControl
  import keySetPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] pressIn,
  output ctrlToPath_t         ctrl,
  output logic                ledOn
);
  localparam logic [SEL_W-1:0] LAST_DIGIT = SEL_W'(NUM_DIGITS - 1);

  setMode_e         modeQ;
  setMode_e         modeNext;
  logic [SEL_W-1:0] digitQ;
  logic             inSetting;

  always_comb begin
    case (modeQ)
      MODE_RUN:  modeNext = MODE_DATE;
      MODE_DATE: modeNext = MODE_TIME;
      default:   modeNext = MODE_RUN;
    endcase
  end

  assign inSetting = (modeQ != MODE_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_RUN;
      digitQ <= '0;
    end else if (pressIn[0]) begin
      modeQ  <= modeNext;
      digitQ <= '0;
    end else if (pressIn[1] && inSetting) begin
      digitQ <= (digitQ == LAST_DIGIT) ? '0 : digitQ + 1'b1;
    end
  end

  assign ctrl.incReq = pressIn[2] && inSetting;
  assign ctrl.mode   = modeQ;
  assign ctrl.digit  = digitQ;
  assign ledOn       = inSetting;
endmodule

// File: rtl/setDatapath.sv
module setDatapath
  import keySetPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlToPath_t           ctrl,
  output logic [NUM_DIGITS-1:0] dateStb,
  output logic [NUM_DIGITS-1:0] timeStb,
  output logic [3:0]            topValue
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stb
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dateStb[i] <= 1'b0;
        timeStb[i] <= 1'b0;
      end else begin
        dateStb[i] <= ctrl.incReq && (ctrl.mode == MODE_DATE) && (ctrl.digit == SEL_W'(i));
        timeStb[i] <= ctrl.incReq && (ctrl.mode == MODE_TIME) && (ctrl.digit == SEL_W'(i));
      end
    end
  end

  assign topValue = digitTop(ctrl.mode, ctrl.digit);
endmodule

// File: rtl/keySetCtrl.sv
module keySetCtrl
  import keySetPkg::*;
#(
  parameter int DEB_CYCLES = 1250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  keyRaw,
  output logic [1:0]  modeOut,
  output logic [2:0]  digitSel,
  output logic [5:0]  dateIncStb,
  output logic [5:0]  timeIncStb,
  output logic [3:0]  digitMax,
  output logic        ledSetting
);
  logic [NUM_KEYS-1:0] pressPulse;
  ctrlToPath_t         ctrl;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    keyDebounce #(.DEB_CYCLES(DEB_CYCLES)) deb_i (
      .clk        (clk),
      .rstN       (rstN),
      .keyIn      (keyRaw[k]),
      .pressPulse (pressPulse[k])
    );
  end

  setControl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .pressIn (pressPulse),
    .ctrl    (ctrl),
    .ledOn   (ledSetting)
  );

  setDatapath path_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dateStb  (dateIncStb),
    .timeStb  (timeIncStb),
    .topValue (digitMax)
  );

  assign modeOut  = ctrl.mode;
  assign digitSel = ctrl.digit;
endmodule

// File: rtl/keySetCtrl_chk.sv
module keySetCtrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeOut,
  input logic [2:0] digitSel,
  input logic [5:0] dateIncStb,
  input logic [5:0] timeIncStb,
  input logic       ledSetting
);
  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != 2'd3));

  assert_mode_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0) |=> (modeOut == 2'd0 || modeOut == 2'd1));

  assert_sel_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (digitSel <= 3'd5));

  assert_sel_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != $past(modeOut)) |-> (digitSel == 3'd0));

  assert_run_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0) |=> (dateIncStb == 6'd0 && timeIncStb == 6'd0));

  assert_date_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dateIncStb) && !((|dateIncStb) && (|timeIncStb)));

  assert_date_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|dateIncStb) |=> (dateIncStb == 6'd0));

  assert_time_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|timeIncStb) |=> ($onehot0(timeIncStb) && timeIncStb == 6'd0));

  assert_led_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != 2'd0) |-> ledSetting);
endmodule

bind keySetCtrl keySetCtrl_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .modeOut    (modeOut),
  .digitSel   (digitSel),
  .dateIncStb (dateIncStb),
  .timeIncStb (timeIncStb),
  .ledSetting (ledSetting)
);

// File: tb/keySetCtrl_tb_top.sv
module keySetCtrl_tb_top;
  localparam int DEB = 16;
  localparam int HOLD = DEB + 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] keyRaw = 3'b000;
  logic [1:0] modeOut;
  logic [2:0] digitSel;
  logic [5:0] dateIncStb;
  logic [5:0] timeIncStb;
  logic [3:0] digitMax;
  logic       ledSetting;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    bit isTime;
    int digit;
    int top;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  keySetCtrl #(.DEB_CYCLES(DEB)) dut_i (
    .clk(clk), .rstN(rstN), .keyRaw(keyRaw), .modeOut(modeOut),
    .digitSel(digitSel), .dateIncStb(dateIncStb), .timeIncStb(timeIncStb),
    .digitMax(digitMax), .ledSetting(ledSetting)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expTop(input bit isTime, input int d);
    int dateTop[6] = '{9, 9, 1, 9, 3, 9};
    int timeTop[6] = '{2, 9, 5, 9, 5, 9};
    return isTime ? timeTop[d] : dateTop[d];
  endfunction

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input int k, input int hold);
    @(negedge clk);
    keyRaw[k] = 1'b1;
    waitCycles(hold);
    keyRaw[k] = 1'b0;
    waitCycles(HOLD);
  endtask

  task automatic pushInc(input bit isTime, input int d);
    expItem_t it;
    it.isTime = isTime;
    it.digit  = d;
    it.top    = expTop(isTime, d);
    expQ.push_back(it);
    press(2, HOLD);
    check(expQ.size() == 0, isTime ? "R8 strobe seen" : "R7 strobe seen", expQ.size(), 0);
  endtask

  // monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rstN && ((|dateIncStb) || (|timeIncStb))) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6/R3 unexpected strobe", {dateIncStb, timeIncStb}, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(dateIncStb == (it.isTime ? 6'd0 : 6'(1 << it.digit)),
              it.isTime ? "R8 date bits" : "R7 date bits", dateIncStb,
              it.isTime ? 0 : (1 << it.digit));
        check(timeIncStb == (it.isTime ? 6'(1 << it.digit) : 6'd0),
              it.isTime ? "R8 time bits" : "R7 time bits", timeIncStb,
              it.isTime ? (1 << it.digit) : 0);
        check(int'(digitMax) == it.top, "R9 digit top", digitMax, it.top);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitCycles(4);
    // R1 reset state
    check(modeOut == 2'd0, "R1 mode", modeOut, 0);
    check(digitSel == 3'd0, "R1 digit", digitSel, 0);
    check(ledSetting == 1'b0, "R1 led", ledSetting, 0);
    check(digitMax == 4'd0, "R1 digitMax", digitMax, 0);
    check(dateIncStb == 6'd0 && timeIncStb == 6'd0, "R1 strobes", {dateIncStb, timeIncStb}, 0);
    @(negedge clk) rstN = 1'b1;
    waitCycles(4);

    // R6 select and increment ignored in run mode
    press(1, HOLD);
    press(2, HOLD);
    check(digitSel == 3'd0, "R6 digit in run", digitSel, 0);
    check(modeOut == 2'd0, "R6 mode in run", modeOut, 0);

    // R3 glitch on mode key
    press(0, DEB / 2);
    check(modeOut == 2'd0, "R3 glitch ignored", modeOut, 0);

    // R2 enter date setting, R10 led
    press(0, HOLD);
    check(modeOut == 2'd1, "R2 to date", modeOut, 1);
    check(ledSetting == 1'b1, "R10 led date", ledSetting, 1);
    check(digitMax == 4'd9, "R9 date digit0", digitMax, 9);

    // R7/R9 every date digit, R4 stepping
    for (int d = 0; d < 6; d++) begin
      check(int'(digitSel) == d, "R4 step", digitSel, d);
      pushInc(1'b0, d);
      press(1, HOLD);
    end
    check(digitSel == 3'd0, "R4 wrap", digitSel, 0);

    // R3 long hold yields one strobe only; glitch yields none
    begin
      expItem_t it;
      it.isTime = 1'b0; it.digit = 0; it.top = expTop(1'b0, 0);
      expQ.push_back(it);
      press(2, 4 * DEB);
      check(expQ.size() == 0, "R3 long hold one event", expQ.size(), 0);
    end
    press(2, DEB / 2);

    // R5 mode change clears selection
    press(1, HOLD);
    press(1, HOLD);
    press(1, HOLD);
    check(digitSel == 3'd3, "R4 at three", digitSel, 3);
    press(0, HOLD);
    check(modeOut == 2'd2, "R2 to time", modeOut, 2);
    check(digitSel == 3'd0, "R5 clear on change", digitSel, 0);
    check(ledSetting == 1'b1, "R10 led time", ledSetting, 1);

    // R8/R9 every time digit
    for (int d = 0; d < 6; d++) begin
      pushInc(1'b1, d);
      press(1, HOLD);
    end

    // R2 back to run, R6 ignored again
    press(1, HOLD);
    press(0, HOLD);
    check(modeOut == 2'd0, "R2 back to run", modeOut, 0);
    check(digitSel == 3'd0, "R5 clear to run", digitSel, 0);
    check(ledSetting == 1'b0, "R10 led off", ledSetting, 0);
    check(digitMax == 4'd0, "R9 run top", digitMax, 0);
    press(2, HOLD);
    press(1, HOLD);
    check(digitSel == 3'd0, "R6 digit after run", digitSel, 0);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule